// File: doc/BRIEF.md
# Rate-1/2 Convolutional Encoder, Constraint Length 3

This block turns a serial bit stream into a stream of 2-bit code symbols for forward error correction. Each data bit offered on a valid/ready input enters a three-stage register. The bit moves in at the newest end, and the older contents move one place toward the oldest end. Two parity networks read taps of the updated register and produce one symbol per bit. The block therefore sends out twice as many bits as it takes in.

The symbol is held in an output register and presented with its own valid signal in the cycle after the bit is accepted. Back-pressure on the output holds the input off, so no symbol is ever lost. The current trellis state, made of the two newest register bits, is visible at all times. A decoder model or a tail-bit sequencer can watch it there. A synchronous clear returns the encoder to the all-zero state and drops any symbol that has not yet been taken. Tail bits are added by feeding zeros through the normal input.

Top module: `conv_enc_k3`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0, `state` is 2'b00 and the register holds all zeros.
- R2: Call the register stages n0 (newest), n1 and n2 (oldest). When a bit is accepted, n2 takes n1, n1 takes n0 and n0 takes the bit. `state` shows {n0, n1}, with n0 in bit 1.
- R3: `out_sym[1]` of each symbol is n0 XOR n1 XOR n2, taken from the register after the shift.
- R4: `out_sym[0]` of each symbol is n0 XOR n2, taken from the register after the shift.
- R5: A bit is accepted in a cycle where `in_valid` and `in_ready` are both high. Its symbol appears with `out_valid` high in the next cycle. With `out_ready` held high, one bit is accepted every cycle.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_sym` and `state` hold their values.
- R7: When `clr` is high, `in_ready` is low and the input bit is ignored. After the edge, the register is zero, `state` is 2'b00 and `out_valid` is 0. Any pending symbol is discarded and no symbol is emitted for that cycle.
- R8: From the zero state, the bits 1,0,0,1,1 produce the symbols 2'b11, 2'b10, 2'b11, 2'b11, 2'b01 in that order, and leave `state` at 2'b11.
- R9: A cycle with `in_valid` low changes neither the register nor `state`. Once the held symbol is taken, `out_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of register and pending symbol |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Encoder can accept a bit this cycle |
| in_bit | input | 1 | Data bit to encode |
| out_valid | output | 1 | `out_sym` holds a symbol not yet taken |
| out_ready | input | 1 | Consumer takes the symbol this cycle |
| out_sym | output | 2 | Code symbol, first parity in bit 1 |
| state | output | 2 | Trellis state {n0, n1} |

## Verification
The hardest case to reach from the ports is a clear that arrives while a symbol is stalled and a new bit is being offered. In that cycle, clear, back-pressure and a handshake all compete. The stimulus first fills the output register with `out_ready` low, then raises `clr` with `in_valid` high. It checks that the stalled symbol disappears and that the offered bit leaves no trace in `state`. A long pseudo-random run then toggles `in_valid`, `out_ready` and occasionally `clr` against a behavioural model, so that stalls of many lengths and back-to-back acceptances are mixed.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int unsigned CE_KMAX = 16;

  // parity of the register bits selected by a generator mask
  function automatic logic tap_parity(input logic [CE_KMAX-1:0] regv,
                                      input logic [CE_KMAX-1:0] gmask);
    return ^(regv & gmask);
  endfunction

  // register value after one bit enters at the newest end
  function automatic logic [CE_KMAX-1:0] push_bit(input logic [CE_KMAX-1:0] regv,
                                                  input logic newb);
    return {regv[CE_KMAX-2:0], newb};
  endfunction
endpackage

// File: rtl/conv_enc_sreg.sv
module conv_enc_sreg #(
  parameter int unsigned K = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [K-1:0] sr,
  output logic [K-1:0] sr_next
);
  import conv_enc_pkg::*;

  logic [CE_KMAX-1:0] pushed;

  always_comb begin
    pushed  = push_bit(CE_KMAX'(sr), din);
    sr_next = pushed[K-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (clr)    sr <= '0;
    else if (shift)  sr <= sr_next;
  end
endmodule

// File: rtl/conv_enc_taps.sv
module conv_enc_taps #(
  parameter int unsigned       K    = 3,
  parameter int unsigned       NOUT = 2,
  parameter logic [NOUT*K-1:0] GENS = 6'b101_111
) (
  input  logic [K-1:0]    regv,
  output logic [NOUT-1:0] sym
);
  import conv_enc_pkg::*;

  // generator o drives symbol bit NOUT-1-o, so the first generator is the MSB
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    localparam logic [K-1:0] GMASK = GENS[o*K +: K];
    assign sym[NOUT-1-o] = tap_parity(CE_KMAX'(regv), CE_KMAX'(GMASK));
  end
endmodule

// File: rtl/conv_enc_obuf.sv
module conv_enc_obuf #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         room
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clr) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_enc_k3.sv
module conv_enc_k3 #(
  parameter int unsigned       K    = 3,
  parameter int unsigned       NOUT = 2,
  parameter logic [NOUT*K-1:0] GENS = 6'b101_111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [NOUT-1:0] out_sym,
  output logic [K-2:0]    state
);
  localparam int unsigned SW = K - 1;

  logic [K-1:0]    sr;
  logic [K-1:0]    sr_next;
  logic [NOUT-1:0] sym_next;
  logic            room;
  logic            take;

  assign in_ready = room && !clr;
  assign take     = in_valid && in_ready;

  conv_enc_sreg #(.K(K)) u_sreg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .shift(take), .din(in_bit),
    .sr(sr), .sr_next(sr_next)
  );

  conv_enc_taps #(.K(K), .NOUT(NOUT), .GENS(GENS)) u_taps (
    .regv(sr_next), .sym(sym_next)
  );

  conv_enc_obuf #(.W(NOUT)) u_obuf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(take), .din(sym_next),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_sym), .room(room)
  );

  // newest stage in the MSB of the state
  for (genvar i = 0; i < SW; i++) begin : g_state
    assign state[SW-1-i] = sr[i];
  end
endmodule

// File: rtl/conv_enc_k3_chk.sv
module conv_enc_k3_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_bit,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_sym,
  input logic [1:0] state,
  input logic       take
);
  // R1
  always_comb begin
    if (!rst_n) reset_idle_chk: assert (!out_valid && state == 2'b00);
  end

  // R2
  new_bit_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> state == {$past(in_bit), $past(state[1])});

  // R5
  sym_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R6
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  stall_holds_sym_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> out_valid && $stable(out_sym) && $stable(state));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid && state == 2'b00);

  // R9
  idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(state));
endmodule

bind conv_enc_k3 conv_enc_k3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
  .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
  .out_sym(out_sym), .state(state), .take(take)
);

// File: tb/tb_conv_enc_k3.sv
module tb_conv_enc_k3;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [1:0] out_sym;
  logic [1:0] state;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural model: three stages kept as integers, newest first
  int m_n0 = 0, m_n1 = 0, m_n2 = 0;
  int m_ov = 0;
  int m_p = 0, m_q = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_enc_k3 dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .state(state)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check in_ready, step model, check after edge
  task automatic step(input bit v, input bit b, input bit rdy, input bit c);
    int exp_ready;
    int ones;
    in_valid = v; in_bit = b; out_ready = rdy; clr = c;
    #1;
    exp_ready = ((m_ov == 0 || rdy) && !c) ? 1 : 0;
    check(in_ready == exp_ready[0], c ? "R7" : "R6", in_ready, exp_ready);
    if (c) begin
      m_n0 = 0; m_n1 = 0; m_n2 = 0; m_ov = 0;
    end else begin
      if (m_ov != 0 && rdy) m_ov = 0;
      if (v && exp_ready != 0) begin
        m_n2 = m_n1; m_n1 = m_n0; m_n0 = b;
        ones = m_n0 + m_n1 + m_n2;
        m_p = ones % 2;
        m_q = (m_n0 != m_n2) ? 1 : 0;
        m_ov = 1;
      end
    end
    @(negedge clk);
    check(out_valid == m_ov[0], "R5", out_valid, m_ov);
    check(state == {m_n0[0], m_n1[0]}, "R2", state, m_n0 * 2 + m_n1);
    if (m_ov != 0) begin
      check(out_sym[1] == m_p[0], "R3", out_sym[1], m_p);
      check(out_sym[0] == m_q[0], "R4", out_sym[0], m_q);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] expq[$];
    logic [15:0] lfsr;
    bit          seq[5];
    int          held;
    seq = '{1, 0, 0, 1, 1};
    expq = '{2'b11, 2'b10, 2'b11, 2'b11, 2'b01};

    // R1: during reset and just after release
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(state == 2'b00, "R1", state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && state == 2'b00, "R1", {out_valid, state}, 0);

    // R8: known sequence at full rate
    foreach (seq[i]) begin
      step(1, seq[i], 1, 0);
      check(out_sym == expq[0], "R8", out_sym, expq[0]);
      void'(expq.pop_front());
    end
    check(state == 2'b11, "R8", state, 3);

    // R9: idle cycles, symbol drains, state kept
    step(0, 0, 1, 0);
    check(out_valid == 1'b0, "R9", out_valid, 0);
    check(state == 2'b11, "R9", state, 3);
    step(0, 1, 1, 0);
    check(state == 2'b11, "R9", state, 3);

    // R6: stall then release
    step(1, 0, 0, 0);
    held = out_sym;
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    check(out_sym == held[1:0], "R6", out_sym, held);
    step(1, 1, 1, 0);

    // R7: clear while a symbol is stalled and a bit is offered
    step(1, 1, 0, 0);
    step(1, 1, 0, 1);
    check(out_valid == 1'b0, "R7", out_valid, 0);
    check(state == 2'b00, "R7", state, 0);
    step(0, 0, 0, 0);
    check(out_valid == 1'b0, "R7", out_valid, 0);

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[3], lfsr[7] | lfsr[9], (lfsr[15:11] == 5'b10110));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule